// File: doc/BRIEF.md
# UART Receiver Time-out Detector

This block watches the receive side of a FIFO-buffered UART and raises a flag when received bytes have been sitting in the receive FIFO for too long. That happens when the byte count stays below the interrupt trigger level and neither the host nor the line has done anything for a while. The interrupt logic turns the flag into a request, so the host can drain the leftover bytes that would never reach the trigger on their own.

The detector counts oversampling baud ticks. A new count window starts at the centre of each received stop bit, on every write into the receive FIFO, and on every host read. The window is four character times long. One character time is the whole serial frame, including start and stop bits, multiplied by the oversampling ratio. The flag can only be raised while FIFO mode is on and the FIFO holds at least one byte. Once raised, it stays up until a read or another restart event takes it down.

Top module: `rx_tmo_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tmo_flag` is 0.
- R2: While `fifo_mode` is 0, `tmo_flag` is 0 in the following cycle. Ticks seen in that state do not count toward a later window.
- R3: While `rx_empty` is 1, `tmo_flag` is 0 in the following cycle. Ticks seen in that state do not count toward a later window.
- R4: The window length is L = 64 × (1 + D + P + S) ticks, with 16 ticks per bit and 4 characters per window. D is 5 + `fmt_dlen` (codes 0..3 give 5..8 data bits). P is `fmt_par`. S is 1 + `fmt_stop2`. Counting from the last restart, `tmo_flag` is 0 after L−1 ticks and 1 in the cycle after the L-th tick.
- R5: A pulse on `rx_rd` restarts the count from zero.
- R6: A pulse on `rx_wr` restarts the count from zero.
- R7: A pulse on `stop_mid` restarts the count from zero.
- R8: Once set, `tmo_flag` stays 1 while ticks continue, as long as no restart event occurs and the detector stays armed.
- R9: A `rx_rd` pulse while the flag is set drops `tmo_flag` to 0 in the following cycle. `rx_wr` and `stop_mid` also clear the flag.
- R10: Emptying the FIFO, or leaving FIFO mode, clears a set flag. After re-arming, a full window of L ticks is needed again.
- R11: A format change takes effect on the next tick. If the count already reaches the new, shorter window, the flag rises on that tick.
- R12: The flag only rises in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle oversampling tick (16 per bit) |
| stop_mid | input | 1 | Pulse at the centre of a received stop bit |
| rx_wr | input | 1 | Receive FIFO write strobe |
| rx_rd | input | 1 | Host read strobe of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| fifo_mode | input | 1 | FIFO mode enabled |
| fmt_dlen | input | 2 | Data bits code, 0..3 gives 5..8 |
| fmt_par | input | 1 | Parity bit present |
| fmt_stop2 | input | 1 | Two stop bits |
| tmo_flag | output | 1 | Receive time-out flag |

## Verification
The bench sweeps all sixteen frame formats and places the flag edge exactly. The flag must be low after L−1 ticks and high after L. An off-by-one in the counter, or a term missing from the frame length, such as the parity bit or the second stop bit, would shift the edge and fail. Each of the three restart sources is pulsed in mid-window and the full window is then counted again. A source that does not restart would raise the flag early. Disarming is checked both by ticking while disarmed and by disarming with the flag already set. A detector that keeps its count across disarm would fire early after re-arming, and one that keeps the flag would stay high. Shrinking the format below the current count catches a limit that is not recomputed.

// File: rtl/rx_tmo_pkg.sv
package rx_tmo_pkg;

    // Frame format as seen by the detector.
    typedef struct packed {
        logic [1:0] dlen;   // 0..3 -> 5..8 data bits
        logic       par;    // parity bit present
        logic       stop2;  // two stop bits
    } frame_fmt_t;

    // Longest frame: start + 8 data + parity + 2 stop.
    localparam int unsigned MAX_FRAME_BITS = 12;

    // Serial bits in one frame, start and stop bits included.
    function automatic int unsigned frame_bits(frame_fmt_t f);
        return 32'd7 + 32'(f.dlen) + 32'(f.par) + 32'(f.stop2);
    endfunction

endpackage

// File: rtl/rx_tmo_limit.sv
module rx_tmo_limit
    import rx_tmo_pkg::*;
#(
    parameter int unsigned OVS   = 16,
    parameter int unsigned NCHAR = 4,
    parameter int unsigned CW    = 10
) (
    input  frame_fmt_t    fmt,
    output logic [CW-1:0] limit
);
    localparam int unsigned TICKS_PER_BIT_WIN = OVS * NCHAR;

    // Purely combinational, so a format change is seen on the next tick.
    always_comb begin
        limit = CW'(frame_bits(fmt) * TICKS_PER_BIT_WIN);
    end
endmodule

// File: rtl/rx_tmo_count.sv
module rx_tmo_count #(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          flag
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } st_t;

    st_t st_d, st_q;
    logic [CW:0] cnt_inc;
    logic        reached;

    always_comb begin
        cnt_inc = {1'b0, st_q.cnt} + {{CW{1'b0}}, 1'b1};
        reached = tick && (cnt_inc >= {1'b0, limit});
        st_d    = st_q;
        if (!armed || restart) begin
            // Disarm and every restart source zero the window.
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else begin
            // The count saturates at the limit, so the flag can be held.
            if (tick && (st_q.cnt < limit)) begin
                st_d.cnt = cnt_inc[CW-1:0];
            end
            st_d.flag = st_q.flag | reached;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/rx_tmo_detect.sv
module rx_tmo_detect
    import rx_tmo_pkg::*;
#(
    parameter int unsigned OVS   = 16,
    parameter int unsigned NCHAR = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       stop_mid,
    input  logic       rx_wr,
    input  logic       rx_rd,
    input  logic       rx_empty,
    input  logic       fifo_mode,
    input  logic [1:0] fmt_dlen,
    input  logic       fmt_par,
    input  logic       fmt_stop2,
    output logic       tmo_flag
);
    localparam int unsigned MAX_LIMIT = OVS * NCHAR * MAX_FRAME_BITS;
    localparam int unsigned CW        = $clog2(MAX_LIMIT + 1);

    frame_fmt_t    fmt;
    logic [CW-1:0] limit;
    logic          armed;
    logic          restart;

    always_comb begin
        fmt.dlen  = fmt_dlen;
        fmt.par   = fmt_par;
        fmt.stop2 = fmt_stop2;
        armed     = fifo_mode && !rx_empty;
        restart   = stop_mid || rx_wr || rx_rd;
    end

    rx_tmo_limit #(.OVS(OVS), .NCHAR(NCHAR), .CW(CW)) u_limit (
        .fmt   (fmt),
        .limit (limit)
    );

    rx_tmo_count #(.CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .restart (restart),
        .tick    (baud_tick),
        .limit   (limit),
        .flag    (tmo_flag)
    );
endmodule

// File: rtl/rx_tmo_checker.sv
module rx_tmo_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       stop_mid,
    input logic       rx_wr,
    input logic       rx_rd,
    input logic       rx_empty,
    input logic       fifo_mode,
    input logic [1:0] fmt_dlen,
    input logic       fmt_par,
    input logic       fmt_stop2,
    input logic       tmo_flag
);
    p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !tmo_flag);

    p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> !tmo_flag);

    p_quiet_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |=> !tmo_flag);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd || rx_wr || stop_mid) |=> !tmo_flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && fifo_mode && !rx_empty && !rx_rd && !rx_wr && !stop_mid)
        |=> tmo_flag);

    p_rise_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(baud_tick));
endmodule

bind rx_tmo_detect rx_tmo_checker u_chk (.*);

// File: tb/tb_rx_tmo_detect.sv
module tb_rx_tmo_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       stop_mid = 1'b0;
    logic       rx_wr = 1'b0;
    logic       rx_rd = 1'b0;
    logic       rx_empty = 1'b1;
    logic       fifo_mode = 1'b0;
    logic [1:0] fmt_dlen = 2'd3;
    logic       fmt_par = 1'b0;
    logic       fmt_stop2 = 1'b0;
    logic       tmo_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_tmo_detect dut (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1;
            cyc();
            baud_tick = 1'b0;
        end
    endtask

    task automatic check(input string req, input logic exp);
        total++;
        if (tmo_flag !== exp) begin
            bad++;
            $display("FAIL %s: tmo_flag=%0b expected=%0b", req, tmo_flag, exp);
        end
    endtask

    function automatic int lim(input int dl, input int p, input int s2);
        return 64 * (1 + 5 + dl + p + 1 + s2);
    endfunction

    task automatic set_fmt(input int dl, input int p, input int s2);
        fmt_dlen = 2'(dl);
        fmt_par = 1'(p);
        fmt_stop2 = 1'(s2);
    endtask

    task automatic pulse_stop();
        stop_mid = 1'b1; cyc(); stop_mid = 1'b0;
    endtask

    initial begin
        cyc(); cyc();
        check("R1", 1'b0);
        rst_n = 1'b1;
        cyc();
        check("R1", 1'b0);

        fifo_mode = 1'b1;
        rx_empty = 1'b0;
        // R4 sweep over all formats, with hold (R8) and read clear (R9)
        for (int f = 0; f < 16; f++) begin
            int l;
            set_fmt(f & 3, (f >> 2) & 1, (f >> 3) & 1);
            l = lim(f & 3, (f >> 2) & 1, (f >> 3) & 1);
            pulse_stop();
            ticks(l - 1);
            check("R4", 1'b0);
            ticks(1);
            check("R4", 1'b1);
            ticks(25);
            check("R8", 1'b1);
            cyc();
            check("R8", 1'b1);
            rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
            check("R9", 1'b0);
        end

        // Restart sources mid-window, format 8N1, L = 640
        set_fmt(3, 0, 0);
        pulse_stop();
        ticks(300);
        rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
        ticks(639); check("R5", 1'b0);
        ticks(1);   check("R5", 1'b1);

        pulse_stop();
        ticks(500);
        rx_wr = 1'b1; cyc(); rx_wr = 1'b0;
        ticks(639); check("R6", 1'b0);
        ticks(1);   check("R6", 1'b1);
        rx_wr = 1'b1; cyc(); rx_wr = 1'b0;
        check("R9", 1'b0);

        ticks(400);
        pulse_stop();
        ticks(639); check("R7", 1'b0);
        ticks(1);   check("R7", 1'b1);
        pulse_stop();
        check("R9", 1'b0);

        // Disarmed by FIFO mode off
        fifo_mode = 1'b0;
        ticks(1000);
        check("R2", 1'b0);
        fifo_mode = 1'b1;
        ticks(639); check("R2", 1'b0);
        ticks(1);   check("R2", 1'b1);
        fifo_mode = 1'b0; cyc(); fifo_mode = 1'b1;
        check("R10", 1'b0);
        ticks(639); check("R10", 1'b0);
        ticks(1);   check("R10", 1'b1);

        // Disarmed by empty FIFO
        rx_empty = 1'b1; cyc();
        check("R3", 1'b0);
        ticks(900);
        check("R3", 1'b0);
        rx_empty = 1'b0;
        ticks(639); check("R3", 1'b0);
        ticks(1);   check("R3", 1'b1);
        rx_empty = 1'b1; cyc(); rx_empty = 1'b0;
        check("R10", 1'b0);

        // Format shrink: 8 data, parity, 2 stop (768) -> 5N1 (448)
        set_fmt(3, 1, 1);
        pulse_stop();
        ticks(500);
        check("R11", 1'b0);
        set_fmt(0, 0, 0);
        cyc();
        check("R12", 1'b0);
        ticks(1);
        check("R11", 1'b1);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule